// File: doc/BRIEF.md
# Synchronous Burst Static Memory Front End

This block is the clocked front end of a synchronous burst static memory, with a small array of registers behind it. A burst starts when either of two address strobes is sampled on a rising edge: one strobe belongs to the processor and the other to the cache controller. The strobe captures the external address. From then on an internal two-bit beat counter produces the array address for up to four beats. The counter steps on each edge where the advance input is low. A static order input chooses either a linear wrap or an interleaved (XOR) sequence for the two low address bits. The upper address bits stay fixed for the whole burst.

Reads are flow-through. Once an edge registers an address, the array word at that address appears on the read port within the same cycle, with no output register. A write is decided at the end of a cycle. At the edge that closes the cycle, the enabled byte lanes of the write data are stored at the address that was current during that cycle. A global write enable stores all lanes. A byte-write enable together with a per-lane select stores only the chosen lanes. Output enable and the sleep input act on the bus drive without waiting for a clock. Sleep also drops the block into an idle state, and a new strobe is needed to leave it.

Top module: `sburst_sram`

## Requirements
- R1: An edge with a qualified, selected strobe loads `addr` as the current address. The strobe is qualified if `strobe_p_n` is low with `ce_n` low, or if `strobe_c_n` is low. The block is selected when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0. From that edge the word at `addr` is on `rd_data` and `rd_drive` is 1. This works from either strobe.
- R2: A low `strobe_p_n` while `ce_n` is high has no effect. If no other strobe is present, the burst continues at its current address.
- R3: A qualified strobe while the block is not selected deselects it in one cycle. From that edge `rd_drive` is 0 until the next selected strobe.
- R4: On an edge with no strobe, a low `adv_n` moves the burst to its next beat. A high `adv_n` keeps the current address.
- R5: With `order_lin`=1, address bits [1:0] of beat k equal the loaded bits [1:0] plus k, modulo 4. The upper bits do not change.
- R6: With `order_lin`=0, address bits [1:0] of beat k equal the loaded bits [1:0] XOR k. The upper bits do not change.
- R7: Lane n is bits [9n+8:9n]. Lane n is written when `gw_n`=0, or when `bwe_n`=0 and `bsel_n[n]`=0. The write happens at the edge that ends an active cycle, at that cycle's address. Edges that carry a strobe write nothing, and neither do edges while the block is deselected.
- R8: Read data is flow-through. After an edge, `rd_data` shows the word at the new current address in the same cycle, including a write made at that edge.
- R9: While `oe_n` is high, `rd_drive` is 0 at once, without waiting for a clock. Whenever `rd_drive` is 0, `rd_data` reads 0.
- R10: While `sleep` is high, `rd_drive` is 0 at once and no write happens. After sleep ends, the block stays idle until a selected strobe arrives.
- R11: While `rst_n` is low, and after it is released, the block is idle with `rd_drive`=0.
- R12: After the fourth beat, a further advance wraps to the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | External word address |
| strobe_p_n | input | 1 | Processor address strobe, active low, gated by ce_n |
| strobe_c_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| ce_n | input | 1 | Primary chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte-write selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Asynchronous power-down to idle |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Flow-through read data, zero when not driven |
| rd_drive | output | 1 | Read bus drive enable (bus tri-stated when 0) |

## Verification
The array is first filled with words that encode their own address, so any fault in the burst counter or the order logic returns the wrong word on `rd_data`. That word appears in the same cycle as the bad edge, since nothing sits between the counter and the read port. A wrong select or idle state shows up in `rd_drive` one edge after the strobe or sleep that caused it. A faulty lane decode only shows on a later read of that address, and the bench makes that read within the same or the next cycle.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    adv_n,
  input  logic                    order_lin,
  input  logic                    ce_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    base;
  logic [1:0]       cnt;
  logic [1:0]       lo;
  logic [AW-1:0]    cur_addr;
  logic             act;
  logic             strobe_evt;
  logic             selected;
  logic             wr_ok;
  logic [LANES-1:0] lane_we;

  assign strobe_evt = (!strobe_p_n && !ce_n) || !strobe_c_n;
  assign selected   = !ce_n && cs_hi && !cs_lo_n;

  assign lo       = order_lin ? base[1:0] + cnt : base[1:0] ^ cnt;
  assign cur_addr = {base[AW-1:2], lo};

  always_ff @(posedge clk or negedge rst_n or posedge sleep) begin
    if (!rst_n) begin
      act  <= 1'b0;
      base <= '0;
      cnt  <= '0;
    end else if (sleep) begin
      act <= 1'b0;
    end else if (strobe_evt) begin
      act <= selected;
      if (selected) begin
        base <= addr;
        cnt  <= '0;
      end
    end else if (act && !adv_n) begin
      cnt <= cnt + 2'd1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = !gw_n || (!bwe_n && !bsel_n[g]);
  end

  assign wr_ok = act && !strobe_evt && !sleep;

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_we[l]) mem[cur_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_drive = act && !oe_n && !sleep;
  assign rd_data  = rd_drive ? mem[cur_addr] : '0;
endmodule

module sburst_sram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          oe_n,
  input logic          strobe_p_n,
  input logic          strobe_c_n,
  input logic          ce_n,
  input logic          cs_hi,
  input logic          cs_lo_n,
  input logic          adv_n,
  input logic          order_lin,
  input logic [AW-1:0] addr,
  input logic          rd_drive,
  input logic          act,
  input logic [AW-1:0] cur_addr
);
  logic go, sel;
  assign go  = (!strobe_p_n && !ce_n) || !strobe_c_n;
  assign sel = !ce_n && cs_hi && !cs_lo_n;

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n || sleep)
    go && sel |=> cur_addr == $past(addr) && rd_drive == !oe_n); // R1
  AST_P_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || sleep)
    act && !strobe_p_n && ce_n && strobe_c_n && adv_n |=> act && $stable(cur_addr)); // R2
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n || sleep)
    go && !sel |=> !rd_drive); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n || sleep)
    act && adv_n && !go |=> $stable(cur_addr) || order_lin != $past(order_lin)); // R4
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n || sleep)
    act && !adv_n && !go && order_lin |=> !order_lin ||
      (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1 && cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]))); // R5
  AST_INTL_STEP: assert property (@(posedge clk) disable iff (!rst_n || sleep)
    act && !adv_n && !go && !order_lin |=> order_lin ||
      (cur_addr[0] != $past(cur_addr[0]) && cur_addr[AW-1:2] == $past(cur_addr[AW-1:2]))); // R6
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rd_drive); // R9
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rd_drive); // R10
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !act); // R10
endmodule

bind sburst_sram sburst_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .oe_n(oe_n),
  .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .ce_n(ce_n),
  .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n), .order_lin(order_lin),
  .addr(addr), .rd_drive(rd_drive), .act(act), .cur_addr(cur_addr)
);

// File: tb/sim_sburst_sram.sv
`timescale 1ns/1ps
module sim_sburst_sram;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = '0;
  logic        strobe_p_n = 1, strobe_c_n = 1, adv_n = 1, order_lin = 1;
  logic        ce_n = 0, cs_hi = 1, cs_lo_n = 0;
  logic        gw_n = 1, bwe_n = 1, oe_n = 0, sleep = 0;
  logic [3:0]  bsel_n = 4'hF;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        rd_drive;

  int nchk = 0, nfail = 0;
  logic [35:0] ref_mem [256];

  always #2.5 clk = ~clk;

  sburst_sram u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .strobe_p_n(strobe_p_n),
    .strobe_c_n(strobe_c_n), .adv_n(adv_n), .order_lin(order_lin), .ce_n(ce_n),
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .oe_n(oe_n), .sleep(sleep), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive));

  typedef struct packed {
    logic       src;
    logic       lin;
    logic [7:0] base;
    logic [2:0] advm;
    logic [7:0] lo;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b0, 1'b1, 8'h10, 3'b111, 8'b00_01_10_11},
    '{1'b1, 1'b1, 8'h11, 3'b111, 8'b01_10_11_00},
    '{1'b0, 1'b1, 8'h12, 3'b111, 8'b10_11_00_01},
    '{1'b1, 1'b1, 8'h13, 3'b111, 8'b11_00_01_10},
    '{1'b0, 1'b0, 8'h20, 3'b111, 8'b00_01_10_11},
    '{1'b1, 1'b0, 8'h21, 3'b111, 8'b01_00_11_10},
    '{1'b0, 1'b0, 8'h22, 3'b111, 8'b10_11_00_01},
    '{1'b1, 1'b0, 8'h23, 3'b111, 8'b11_10_01_00},
    '{1'b0, 1'b1, 8'h31, 3'b101, 8'b01_10_10_11},
    '{1'b1, 1'b0, 8'h36, 3'b011, 8'b10_10_11_00}
  };

  function automatic logic [35:0] pat(input logic [7:0] a);
    return {4'hA, a, ~a, a ^ 8'hC3, 8'h3C};
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] on);
    logic [35:0] r = old;
    for (int l = 0; l < 4; l++) if (on[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  task automatic chk(input string req, input logic [35:0] got, input logic [35:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_ctl();
    strobe_p_n = 1; strobe_c_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = 4'hF;
  endtask

  task automatic load(input logic [7:0] a, input logic src);
    @(negedge clk);
    idle_ctl();
    addr = a;
    if (src) strobe_c_n = 0; else strobe_p_n = 0;
    edge_wait();
    strobe_p_n = 1; strobe_c_n = 1;
  endtask

  task automatic beat(input logic adv, input logic gw, input logic bwe,
                      input logic [3:0] bs, input logic [35:0] wd);
    @(negedge clk);
    adv_n = !adv; gw_n = gw; bwe_n = bwe; bsel_n = bs; wr_data = wd;
    edge_wait();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 idle drive after reset", {35'd0, rd_drive}, 36'd0);
    chk("R11 idle data after reset", rd_data, 36'd0);
    @(negedge clk) rst_n = 1;
    #1 chk("R11 idle after release", {35'd0, rd_drive}, 36'd0);

    order_lin = 1;
    for (int b = 0; b < 64; b++) begin
      load(8'(b * 4), b[0]);
      for (int k = 0; k < 4; k++) begin
        beat(1'b1, 1'b0, 1'b1, 4'hF, pat(8'(b * 4 + k)));
        ref_mem[b * 4 + k] = pat(8'(b * 4 + k));
      end
    end

    for (int i = 0; i < 10; i++) begin
      vec_t v = VEC[i];
      string tag = v.advm != 3'b111 ? "R4" : (v.lin ? "R5" : "R6");
      order_lin = v.lin;
      load(v.base, v.src);
      chk("R1 first beat", rd_data, ref_mem[{v.base[7:2], v.lo[7:6]}]);
      chk("R1 drive", {35'd0, rd_drive}, 36'd1);
      for (int k = 0; k < 3; k++) begin
        beat(v.advm[2 - k], 1'b1, 1'b1, 4'hF, '0);
        chk(tag, rd_data, ref_mem[{v.base[7:2], v.lo[5 - 2 * k -: 2]}]);
      end
    end

    // R12 wrap
    order_lin = 1;
    load(8'h46, 1'b0);
    for (int k = 0; k < 4; k++) beat(1'b1, 1'b1, 1'b1, 4'hF, '0);
    chk("R12 wrap to loaded", rd_data, ref_mem[8'h46]);

    // R7 and R8 byte lanes
    load(8'h40, 1'b1);
    beat(1'b0, 1'b1, 1'b0, 4'b1010, 36'h9_8765_4321);
    ref_mem[8'h40] = merge(ref_mem[8'h40], 36'h9_8765_4321, 4'b0101);
    chk("R8 flow-through of lane write", rd_data, ref_mem[8'h40]);
    beat(1'b0, 1'b1, 1'b1, 4'h0, 36'h1_1111_1111);
    chk("R7 selects without byte enable", rd_data, ref_mem[8'h40]);
    beat(1'b0, 1'b0, 1'b1, 4'hF, 36'hF_EDCB_A987);
    ref_mem[8'h40] = 36'hF_EDCB_A987;
    chk("R7 global write", rd_data, ref_mem[8'h40]);

    // R7 strobe edge does not write
    load(8'h50, 1'b0);
    @(negedge clk);
    addr = 8'h60; strobe_p_n = 0; gw_n = 0; wr_data = 36'h0_DEAD_BEEF;
    edge_wait();
    idle_ctl();
    chk("R7 no write on strobe edge (new)", rd_data, ref_mem[8'h60]);
    load(8'h50, 1'b1);
    chk("R7 no write on strobe edge (old)", rd_data, ref_mem[8'h50]);

    // R2 gated processor strobe
    load(8'h70, 1'b0);
    @(negedge clk);
    addr = 8'h99; strobe_p_n = 0; ce_n = 1;
    edge_wait();
    strobe_p_n = 1; ce_n = 0;
    chk("R2 ignored strobe keeps address", rd_data, ref_mem[8'h70]);

    // R3 deselect via cache strobe, then inactive write
    @(negedge clk);
    strobe_c_n = 0; cs_hi = 0;
    edge_wait();
    strobe_c_n = 1; cs_hi = 1;
    chk("R3 cache deselect drive", {35'd0, rd_drive}, 36'd0);
    chk("R3 cache deselect data", rd_data, 36'd0);
    beat(1'b1, 1'b0, 1'b1, 4'hF, 36'h0_BAD0_BAD0);
    chk("R3 stays idle", {35'd0, rd_drive}, 36'd0);
    load(8'h70, 1'b1);
    chk("R7 no write while deselected", rd_data, ref_mem[8'h70]);
    @(negedge clk);
    strobe_p_n = 0; cs_lo_n = 1;
    edge_wait();
    strobe_p_n = 1; cs_lo_n = 0;
    chk("R3 processor deselect", {35'd0, rd_drive}, 36'd0);

    // R9 output enable
    load(8'h72, 1'b0);
    @(negedge clk) oe_n = 1;
    #1 chk("R9 oe off drive", {35'd0, rd_drive}, 36'd0);
    chk("R9 oe off data", rd_data, 36'd0);
    oe_n = 0;
    #1 chk("R9 oe back", rd_data, ref_mem[8'h72]);

    // R10 sleep
    @(negedge clk) sleep = 1;
    #1 chk("R10 sleep quiets bus", {35'd0, rd_drive}, 36'd0);
    beat(1'b1, 1'b0, 1'b1, 4'hF, 36'h0_5555_5555);
    @(negedge clk) begin sleep = 0; idle_ctl(); end
    edge_wait();
    chk("R10 idle after sleep", {35'd0, rd_drive}, 36'd0);
    load(8'h72, 1'b0);
    chk("R10 no write during sleep", rd_data, ref_mem[8'h72]);

    // R11 reset mid-burst
    @(negedge clk) rst_n = 0;
    #1 chk("R11 reset quiets bus", {35'd0, rd_drive}, 36'd0);
    @(negedge clk) rst_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog expired got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule